// File: doc/BRIEF.md
# Serial Channel Control and Interrupt Unit

This unit holds the control register and the status flags of an asynchronous serial channel, and turns them into four interrupt requests: transmit buffer empty, transmission finished, receive buffer full and receive error. A small register bus reaches four byte-wide locations: control, status, transmit byte and received byte. The unit hands a pending transmit byte to a transmit shifter over a valid/ready stream. It accepts completed frames from a receive shifter over a second valid/ready stream.

Status flags follow a read-then-clear discipline. A flag can be cleared only by writing 0 to it after a status read that saw it at 1. A multiprocessor address filter can be armed. While it is armed, frames whose address bit is 0 are dropped without a trace. The first frame whose address bit is 1 is taken normally and disarms the filter by itself.

Both streams follow fixed rules. On the transmit stream, `txs_valid` stays high and `txs_data` stays stable until `txs_ready` is seen high at a clock edge. A handshake marks the byte as taken. Dropping transmit enable withdraws `txs_valid`. On the receive stream, `rxf_ready` is always high, so each cycle with `rxf_valid` high delivers exactly one frame. There is never back-pressure, and frames that arrive while reception is disabled are dropped.

Top module: `uart_ctl_core`

## Requirements
- R1: After reset, the control byte reads 0x00, the status byte reads 0x84 and all four requests are low. Control bits, from bit 7 down, are: transmit IRQ enable, receive IRQ enable, transmit enable, receive enable, address-filter enable, transmit-end IRQ enable, and a 2-bit clock select (bits 1:0, driven on `clk_sel`).
- R2: `irq_txi` equals transmit IRQ enable AND the tx-empty flag (status bit 7). `irq_tei` equals transmit-end IRQ enable AND the tx-end flag (status bit 2).
- R3: With transmit enable set, clearing tx-empty presents the transmit byte on the transmit stream. The byte is held until it is accepted, and acceptance sets tx-empty again.
- R4: Writing 0 to a clearable status bit (7, 6, 5, 4, 3) clears it only if the last status read saw that bit at 1 and no status write has occurred since that read. Writing 1 never clears a bit.
- R5: While transmit enable is 0, tx-empty is forced to 1 and `txs_valid` is low.
- R6: A frame accepted into an empty buffer loads the received byte register (address 3) and sets rx-full (bit 6). A framing error sets bit 4 and a parity error sets bit 3. `irq_rxi` equals receive IRQ enable AND rx-full.
- R7: A frame accepted while rx-full is 1 sets overrun (bit 5) and leaves the received byte unchanged.
- R8: `irq_eri` equals receive IRQ enable AND (overrun OR framing OR parity).
- R9: While receive enable is 0, frames are ignored and the rx flags keep their values.
- R10: While the address-filter enable is 1, a frame with address bit 0 changes no flag and no data, and leaves the filter enabled.
- R11: A frame with address bit 1 is taken normally while the filter is enabled. It sets status bit 1 to 1 and clears the filter enable. Every taken frame copies its address bit into status bit 1.
- R12: A tx-empty clear per R4 also clears tx-end. A `tx_done` pulse while tx-empty is 1 sets tx-end. Tx-end is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 transmit byte, 3 received byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rxf_valid | input | 1 | Completed frame present |
| rxf_ready | output | 1 | Always 1 |
| rxf_data | input | 8 | Received byte |
| rxf_mpb | input | 1 | Address (multiprocessor) bit of frame |
| rxf_ferr | input | 1 | Framing error of frame |
| rxf_perr | input | 1 | Parity error of frame |
| txs_valid | output | 1 | Transmit byte pending |
| txs_ready | input | 1 | Transmit shifter takes byte |
| txs_data | output | 8 | Transmit byte |
| tx_done | input | 1 | Shifter finished the last stop bit |
| tx_on | output | 1 | Transmit enable to shifter |
| rx_on | output | 1 | Receive enable to shifter |
| clk_sel | output | 2 | Clock select bits |
| irq_txi | output | 1 | Transmit-empty request |
| irq_tei | output | 1 | Transmit-end request |
| irq_rxi | output | 1 | Receive-full request |
| irq_eri | output | 1 | Receive-error request |

## Verification
Receive frames are driven in five patterns: a clean frame into an empty buffer, a frame onto a full buffer, a frame with a framing error, a frame with a parity error, and frames sent while reception is off. Together these separate the load path from the overrun path and each error flag from the others. The address filter is tested with address-0 frames before and after an address-1 frame, which shows both the discard and the self-disarm. On the transmit side, one byte is sent with the shifter ready and one with it stalled, and transmit enable is dropped during the stall. A clear without a prior read and a clear after a read show whether the read arming is honoured.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_TXD  = 2'd2,
    A_RXD  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       tx_ie;
    logic       rx_ie;
    logic       tx_en;
    logic       rx_en;
    logic       mp_en;
    logic       te_ie;
    logic [1:0] clk_sel;
  } ctrl_t;

  // status bit positions
  localparam int S_TXE  = 7;
  localparam int S_RXF  = 6;
  localparam int S_OVR  = 5;
  localparam int S_FRM  = 4;
  localparam int S_PAR  = 3;
  localparam int S_TEND = 2;
  localparam int S_MPB  = 1;
  localparam int RX_FLAGS = S_RXF - S_PAR + 1;
endpackage

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
  import uart_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [BUS_W-1:0] wdata,
  input  logic             mp_hit,
  output ctrl_t            ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_t'(wdata);
    else if (mp_hit)  ctrl.mp_en <= 1'b0;
  end
endmodule

// File: rtl/uart_ctl_txf.sv
module uart_ctl_txf
  import uart_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rd_stat,
  input  logic             wr_stat,
  input  logic             wr_txd,
  input  logic [BUS_W-1:0] wdata,
  input  logic             tx_ready,
  input  logic             tx_done,
  output logic             tx_valid,
  output logic [BUS_W-1:0] tx_data,
  output logic             txe,
  output logic             tend
);
  logic arm;
  logic clr_ev;

  assign clr_ev   = wr_stat && !wdata[S_TXE] && arm && tx_en;
  assign tx_valid = tx_en && !txe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe     <= 1'b1;
      tend    <= 1'b1;
      arm     <= 1'b0;
      tx_data <= '0;
    end else begin
      if (rd_stat)      arm <= txe;
      else if (wr_stat) arm <= 1'b0;
      if (wr_txd) tx_data <= wdata;
      if (!tx_en)                    txe <= 1'b1;
      else if (tx_valid && tx_ready) txe <= 1'b1;
      else if (clr_ev)               txe <= 1'b0;
      if (clr_ev)                tend <= 1'b0;
      else if (tx_done && txe)   tend <= 1'b1;
    end
  end

  AST_TXE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txe) else $error("tx-empty not forced"); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_txd) |=> ($stable(tx_data) && (tx_valid || !tx_en)))
    else $error("tx byte dropped"); // R3
endmodule

// File: rtl/uart_ctl_rxf.sv
module uart_ctl_rxf
  import uart_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                mp_en,
  input  logic                rd_stat,
  input  logic                wr_stat,
  input  logic [RX_FLAGS-1:0] wflags,
  input  logic                f_valid,
  input  logic [BUS_W-1:0]    f_data,
  input  logic                f_mpb,
  input  logic                f_ferr,
  input  logic                f_perr,
  output logic [RX_FLAGS-1:0] flg,
  output logic                mpb_q,
  output logic [BUS_W-1:0]    rx_data,
  output logic                mp_hit
);
  // flg index: 3 full, 2 overrun, 1 framing, 0 parity
  localparam int I_FULL = RX_FLAGS - 1;
  localparam int I_OVR  = RX_FLAGS - 2;

  logic take, discard, accept, load;
  logic [RX_FLAGS-1:0] arm, set_v;

  assign take    = f_valid && rx_en;
  assign discard = take && mp_en && !f_mpb;
  assign accept  = take && !discard;
  assign mp_hit  = take && mp_en && f_mpb;
  assign load    = accept && !flg[I_FULL];
  assign set_v   = {load, accept && flg[I_FULL], load && f_ferr, load && f_perr};

  for (genvar i = 0; i < RX_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg[i] <= 1'b0;
        arm[i] <= 1'b0;
      end else begin
        if (rd_stat)      arm[i] <= flg[i];
        else if (wr_stat) arm[i] <= 1'b0;
        if (set_v[i])                            flg[i] <= 1'b1;
        else if (wr_stat && arm[i] && !wflags[i]) flg[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      mpb_q   <= 1'b0;
    end else begin
      if (load)   rx_data <= f_data;
      if (accept) mpb_q   <= f_mpb;
    end
  end

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && flg[I_FULL]) |=> (flg[I_OVR] && $stable(rx_data)))
    else $error("overrun handling"); // R7
  AST_MP_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !wr_stat) |=> ($stable(flg) && $stable(rx_data) && $stable(mpb_q)))
    else $error("filtered frame left a trace"); // R10
  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg[I_FULL]) |-> $past(arm[I_FULL]))
    else $error("rx-full cleared without read"); // R4
endmodule

// File: rtl/uart_ctl_core.sv
module uart_ctl_core
  import uart_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rxf_valid,
  output logic              rxf_ready,
  input  logic [BUS_W-1:0]  rxf_data,
  input  logic              rxf_mpb,
  input  logic              rxf_ferr,
  input  logic              rxf_perr,
  output logic              txs_valid,
  input  logic              txs_ready,
  output logic [BUS_W-1:0]  txs_data,
  input  logic              tx_done,
  output logic              tx_on,
  output logic              rx_on,
  output logic [1:0]        clk_sel,
  output logic              irq_txi,
  output logic              irq_tei,
  output logic              irq_rxi,
  output logic              irq_eri
);
  ctrl_t                ctrl;
  logic                 wr_ctrl, wr_stat, wr_txd, rd_stat, mp_hit;
  logic                 txe, tend, mpb_q;
  logic [RX_FLAGS-1:0]  rflg;
  logic [BUS_W-1:0]     rx_data, status;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
  assign wr_txd  = bus_sel && bus_wr && (bus_addr == A_TXD);
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);

  uart_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .mp_hit(mp_hit), .ctrl(ctrl)
  );

  uart_ctl_txf u_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(ctrl.tx_en), .rd_stat(rd_stat),
    .wr_stat(wr_stat), .wr_txd(wr_txd), .wdata(bus_wdata),
    .tx_ready(txs_ready), .tx_done(tx_done), .tx_valid(txs_valid),
    .tx_data(txs_data), .txe(txe), .tend(tend)
  );

  uart_ctl_rxf u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(ctrl.rx_en), .mp_en(ctrl.mp_en),
    .rd_stat(rd_stat), .wr_stat(wr_stat), .wflags(bus_wdata[S_RXF:S_PAR]),
    .f_valid(rxf_valid), .f_data(rxf_data), .f_mpb(rxf_mpb),
    .f_ferr(rxf_ferr), .f_perr(rxf_perr), .flg(rflg), .mpb_q(mpb_q),
    .rx_data(rx_data), .mp_hit(mp_hit)
  );

  assign status    = {txe, rflg, tend, mpb_q, 1'b0};
  assign rxf_ready = 1'b1;
  assign tx_on     = ctrl.tx_en;
  assign rx_on     = ctrl.rx_en;
  assign clk_sel   = ctrl.clk_sel;
  assign irq_txi   = ctrl.tx_ie && txe;
  assign irq_tei   = ctrl.te_ie && tend;
  assign irq_rxi   = ctrl.rx_ie && rflg[RX_FLAGS-1];
  assign irq_eri   = ctrl.rx_ie && (|rflg[RX_FLAGS-2:0]);

  always_comb begin
    unique case (reg_addr_e'(bus_addr))
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = status;
      A_TXD:   bus_rdata = txs_data;
      default: bus_rdata = rx_data;
    endcase
  end

  AST_MP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_hit && !wr_ctrl) |=> !ctrl.mp_en) else $error("filter not disarmed"); // R11
  AST_TEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && txe) |=> tend) else $error("tx-end not set"); // R12
endmodule

// File: tb/sim_uart_ctl_core.sv
module sim_uart_ctl_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       rxf_valid = 0, rxf_ready, rxf_mpb = 0, rxf_ferr = 0, rxf_perr = 0;
  logic [7:0] rxf_data = 0;
  logic       txs_valid, txs_ready = 1'b1, tx_done = 0, tx_on, rx_on;
  logic [7:0] txs_data;
  logic [1:0] clk_sel;
  logic       irq_txi, irq_tei, irq_rxi, irq_eri;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd;

  always #5 clk = ~clk;

  uart_ctl_core u0 (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic frame(logic [7:0] d, logic m, logic fe, logic pe);
    @(negedge clk); rxf_valid = 1; rxf_data = d; rxf_mpb = m; rxf_ferr = fe; rxf_perr = pe;
    @(negedge clk); rxf_valid = 0;
  endtask

  // transmit driver pushes the expected byte
  task automatic send(logic [7:0] d);
    exp_q.push_back(d);
    brd(1, rd);
    bwr(2, d);
    bwr(1, 8'h7F);
  endtask

  // monitor: compares every accepted transmit byte
  always begin
    @(negedge clk); #2;
    if (txs_valid && txs_ready) begin
      if (exp_q.size() == 0) chk("R3 unexpected tx byte", txs_data, 8'hxx);
      else chk("R3 tx byte", txs_data, exp_q.pop_front());
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    brd(0, rd); chk("R1 ctrl reset", rd, 8'h00);
    brd(1, rd); chk("R1 status reset", rd, 8'h84);
    chk("R1 irqs reset", {4'h0, irq_txi, irq_tei, irq_rxi, irq_eri}, 8'h00);
    bwr(1, 8'hFF);                      // drops read arming, clears nothing
    bwr(0, 8'hA0);
    chk("R2 txi", {7'h0, irq_txi}, 8'h01);
    bwr(1, 8'h7F);                      // no prior read
    brd(1, rd); chk("R4 clear without read", rd, 8'h84);
    send(8'hA5);
    repeat (2) @(negedge clk);
    brd(1, rd); chk("R12 tend cleared with txe", rd, 8'h80);
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    bwr(0, 8'hA4);
    chk("R2 tei", {7'h0, irq_tei}, 8'h01);
    // stalled shifter, then transmit disabled
    txs_ready = 0;
    brd(1, rd); bwr(2, 8'h5A); bwr(1, 8'h7F);
    repeat (3) @(negedge clk);
    chk("R3 held valid", {7'h0, txs_valid}, 8'h01);
    chk("R3 held data", txs_data, 8'h5A);
    chk("R2 txi low while busy", {7'h0, irq_txi}, 8'h00);
    bwr(0, 8'h84);
    chk("R5 valid withdrawn", {7'h0, txs_valid}, 8'h00);
    @(negedge clk);
    brd(1, rd); chk("R5 txe forced", rd, 8'h80);
    txs_ready = 1;
    // receive path
    bwr(0, 8'h50);
    frame(8'h3C, 0, 0, 0);
    chk("R6 rxi/eri", {6'h0, irq_rxi, irq_eri}, 8'h02);
    brd(3, rd); chk("R6 rx data", rd, 8'h3C);
    brd(1, rd); chk("R6 status", rd, 8'hC0);
    frame(8'h11, 0, 0, 0);
    chk("R8 eri on overrun", {7'h0, irq_eri}, 8'h01);
    brd(3, rd); chk("R7 data kept", rd, 8'h3C);
    brd(1, rd); chk("R7 overrun status", rd, 8'hE0);
    bwr(1, 8'h9F);
    chk("R4 irqs after clear", {6'h0, irq_rxi, irq_eri}, 8'h00);
    brd(1, rd); chk("R4 status after clear", rd, 8'h80);
    frame(8'h99, 0, 1, 0);
    brd(1, rd); chk("R6 framing", rd, 8'hD0);
    chk("R8 eri framing", {7'h0, irq_eri}, 8'h01);
    bwr(0, 8'h40);
    brd(1, rd); chk("R9 flags kept", rd, 8'hD0);
    frame(8'h22, 0, 0, 0);
    brd(3, rd); chk("R9 frame ignored data", rd, 8'h99);
    brd(1, rd); chk("R9 frame ignored status", rd, 8'hD0);
    bwr(1, 8'hAF);
    brd(1, rd); chk("R4 partial clear", rd, 8'h80);
    bwr(0, 8'h50);
    frame(8'h0F, 0, 0, 1);
    brd(1, rd); chk("R6 parity", rd, 8'hC8);
    chk("R8 eri parity", {7'h0, irq_eri}, 8'h01);
    bwr(1, 8'hB7);
    brd(1, rd); chk("R4 parity clear", rd, 8'h80);
    // address filter
    bwr(0, 8'h58);
    frame(8'h77, 0, 0, 0);
    brd(1, rd); chk("R10 discard status", rd, 8'h80);
    chk("R10 no rxi", {7'h0, irq_rxi}, 8'h00);
    brd(3, rd); chk("R10 discard data", rd, 8'h0F);
    brd(0, rd); chk("R10 filter stays", rd, 8'h58);
    frame(8'h42, 1, 0, 0);
    brd(1, rd); chk("R11 address frame status", rd, 8'hC2);
    brd(0, rd); chk("R11 filter disarmed", rd, 8'h50);
    brd(3, rd); chk("R11 address data", rd, 8'h42);
    bwr(1, 8'hBF);
    frame(8'h55, 0, 0, 0);
    brd(3, rd); chk("R11 normal after disarm", rd, 8'h55);
    brd(1, rd); chk("R11 mpb follows frame", rd, 8'hC0);
    bwr(0, 8'h03);
    chk("R1 clock select", {6'h0, clk_sel}, 8'h03);
    chk("R3 queue drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule